// File: doc/BRIEF.md
# Single-channel block-copy DMA engine

This block is one DMA channel. Software sets it up through a small register file and then starts it. The setup is:

- a 64-bit source address and a 64-bit destination address;
- for each side, an address behaviour (held fixed or stepping forward) and an access width;
- a unit length in bytes and a number of units;
- a minimum idle spacing between bus requests.

Once started, the engine moves `unit length × unit count` bytes. It works in beats. Each beat is one read on a generic request/acknowledge memory port followed by one write of the same data.

A fixed side suits a device data register. A stepping side suits ordinary memory. When the transfer finishes, a sticky end flag is set. When the bus returns an error, a sticky error flag is set instead. Each flag has its own enable, and the enabled flags drive one interrupt line.

Software can cancel a running transfer by writing 0 to the launch bit. It then polls the activity bit until it reads 0. Setup registers are locked while the channel is active. A launch with an impossible length is refused and reported as an error.

Top module: `dma_chan_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Register reads return data one cycle after `reg_ren`. The fields read back are masked to their defined bits:
  - 0x08: bits 5:0 request selector, bits 23:16 gap.
  - 0x10 (source mode) and 0x14 (destination mode): bit 4 fixed, bits 25:24 width code.
  - 0x20/0x18: source address low/high 32 bits.
  - 0x24/0x1C: destination address low/high 32 bits.
  - 0x28: bits 25:0 unit bytes.
  - 0x2C: bits 15:0 unit count.
  - 0x34: bits 1:0 interrupt enable.
- R3: A valid launch (1 to bit 0 of 0x30) performs `bytes×count/W` beats. W is 2^max(source code, destination code). Each beat is a read (`mem_we`=0) at the source address with `mem_size` = log2 W, then a write (`mem_we`=1) at the destination address carrying the data just read. `mem_req` and its address stay steady until `mem_ack`.
- R4: A side whose mode bit 4 is 1 keeps the same address for every beat. A side whose mode bit 4 is 0 advances by W after each beat. Width codes 0..3 mean 1, 2, 4 and 8 bytes.
- R5: Between the acknowledge of one access and the next request of the same transfer, `mem_req` is low for exactly the gap value in cycles. A gap of 0 means back to back.
- R6: On the final write acknowledge, activity (0x40 bit 0) clears and the end flag (0x44 bit 0) sets.
- R7: An acknowledge with `mem_err` high stops the transfer with no further request. It sets the error flag (0x44 bit 1), clears activity and leaves the end flag at 0.
- R8: A launch with unit bytes 0, or unit bytes not a multiple of W, sets the error flag and makes no access. A launch with count 0 sets the end flag and makes no access.
- R9: Writing 1 to a bit of 0x44 clears that flag. Writing 0 leaves it.
- R10: 0x48 reads flags AND enables. `irq` is the OR of those bits, registered, so it follows one cycle later.
- R11: Writing 0 to 0x30 while active lets any outstanding access finish, issues no new request, clears activity, and sets neither flag.
- R12: While active, writes to 0x08, 0x10–0x2C are ignored, and writing 1 to 0x30 starts nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Access byte address |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| irq | output | 1 | Interrupt |

## Verification
The bound checker watches these properties on every cycle:

- request stability until acknowledge;
- silence of the port when idle;
- the exact idle spacing between requests inside a transfer;
- the halt after an error response;
- the exclusivity of the end and error outcomes.

Some behaviour can only be shown by the bench scenarios. These are the beat count and address sequence for fixed and stepping sides, and the data carried from each read to its write. They also include the refused launches, flag clearing and interrupt masking, the locking of setup during a transfer, and the cancel path with its quiet aftermath.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [7:0] OFS_FACTOR = 8'h08;
  localparam logic [7:0] OFS_SMODE  = 8'h10;
  localparam logic [7:0] OFS_DMODE  = 8'h14;
  localparam logic [7:0] OFS_SHI    = 8'h18;
  localparam logic [7:0] OFS_DHI    = 8'h1C;
  localparam logic [7:0] OFS_SLO    = 8'h20;
  localparam logic [7:0] OFS_DLO    = 8'h24;
  localparam logic [7:0] OFS_BYTES  = 8'h28;
  localparam logic [7:0] OFS_COUNT  = 8'h2C;
  localparam logic [7:0] OFS_LAUNCH = 8'h30;
  localparam logic [7:0] OFS_IEN    = 8'h34;
  localparam logic [7:0] OFS_ACTIVE = 8'h40;
  localparam logic [7:0] OFS_FLAGS  = 8'h44;
  localparam logic [7:0] OFS_DETECT = 8'h48;

  localparam int FLG_END = 0;
  localparam int FLG_ERR = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_GAP} eng_st_t;
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          fix,
  input  logic [1:0]    code,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)               addr <= '0;
    else if (load)         addr <= base;
    else if (adv && !fix)  addr <= addr + (AW'(1) << code);
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int AW  = 64,
  parameter int DW  = 64,
  parameter int SZW = 26,
  parameter int CNW = 16,
  parameter int GPW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic [AW-1:0]  src_base,
  input  logic [AW-1:0]  dst_base,
  input  logic           src_fix,
  input  logic           dst_fix,
  input  logic [1:0]     wcode,
  input  logic [SZW-1:0] unit_bytes,
  input  logic [CNW-1:0] unit_cnt,
  input  logic [GPW-1:0] gap,
  output logic           busy,
  output logic           done_p,
  output logic           err_p,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int NSIDE = 2;

  eng_st_t        st;
  logic [SZW-1:0] left_b;
  logic [CNW-1:0] left_u;
  logic [GPW-1:0] gcnt;
  logic           to_wr, ab_pend, ab, last;
  logic [SZW-1:0] step_b;

  logic [AW-1:0]  side_base [NSIDE];
  logic [AW-1:0]  side_addr [NSIDE];
  logic           side_fix  [NSIDE];
  logic           side_adv  [NSIDE];

  assign step_b = SZW'(1) << wcode;
  assign ab     = ab_pend | abort;
  assign last   = (left_b == step_b) && (left_u == CNW'(1));
  assign busy   = (st != ST_IDLE);
  assign done_p = (st == ST_WR) && mem_ack && !mem_err && !ab && last;
  assign err_p  = ((st == ST_RD) || (st == ST_WR)) && mem_ack && mem_err;

  assign side_base[0] = src_base;
  assign side_base[1] = dst_base;
  assign side_fix[0]  = src_fix;
  assign side_fix[1]  = dst_fix;
  assign side_adv[0]  = (st == ST_RD) && mem_ack && !mem_err && !ab;
  assign side_adv[1]  = (st == ST_WR) && mem_ack && !mem_err && !ab && !last;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_side #(.AW(AW)) u_side (
      .clk  (clk),
      .rst  (rst),
      .load (go && (st == ST_IDLE)),
      .base (side_base[s]),
      .adv  (side_adv[s]),
      .fix  (side_fix[s]),
      .code (wcode),
      .addr (side_addr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      left_b    <= '0;
      left_u    <= '0;
      gcnt      <= '0;
      to_wr     <= 1'b0;
      ab_pend   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st       <= ST_RD;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_base;
          mem_size <= wcode;
          left_b   <= unit_bytes;
          left_u   <= unit_cnt;
          ab_pend  <= 1'b0;
        end
        ST_RD: begin
          ab_pend <= ab;
          if (mem_ack) begin
            mem_wdata <= mem_rdata;
            if (mem_err || ab) begin
              st      <= ST_IDLE;
              mem_req <= 1'b0;
            end else if (gap == '0) begin
              st       <= ST_WR;
              mem_we   <= 1'b1;
              mem_addr <= side_addr[1];
            end else begin
              st      <= ST_GAP;
              mem_req <= 1'b0;
              gcnt    <= gap - 1'b1;
              to_wr   <= 1'b1;
            end
          end
        end
        ST_WR: begin
          ab_pend <= ab;
          if (mem_ack) begin
            if (mem_err || ab || last) begin
              st      <= ST_IDLE;
              mem_req <= 1'b0;
            end else begin
              if (left_b == step_b) begin
                left_b <= unit_bytes;
                left_u <= left_u - 1'b1;
              end else begin
                left_b <= left_b - step_b;
              end
              if (gap == '0) begin
                st       <= ST_RD;
                mem_we   <= 1'b0;
                mem_addr <= side_addr[0];
              end else begin
                st      <= ST_GAP;
                mem_req <= 1'b0;
                gcnt    <= gap - 1'b1;
                to_wr   <= 1'b0;
              end
            end
          end
        end
        ST_GAP: begin
          if (ab) begin
            st      <= ST_IDLE;
            ab_pend <= 1'b0;
          end else if (gcnt == '0) begin
            mem_req  <= 1'b1;
            mem_we   <= to_wr;
            mem_addr <= to_wr ? side_addr[1] : side_addr[0];
            st       <= to_wr ? ST_WR : ST_RD;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs import dma_pkg::*; #(
  parameter int AW  = 64,
  parameter int SZW = 26,
  parameter int CNW = 16,
  parameter int GPW = 8,
  parameter int FSW = 6,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wen,
  input  logic           ren,
  input  logic [RAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic           busy,
  input  logic           done_p,
  input  logic           err_p,
  output logic           go,
  output logic           abort,
  output logic [AW-1:0]  src_base,
  output logic [AW-1:0]  dst_base,
  output logic           src_fix,
  output logic           dst_fix,
  output logic [1:0]     wcode,
  output logic [SZW-1:0] unit_bytes,
  output logic [CNW-1:0] unit_cnt,
  output logic [GPW-1:0] gap,
  output logic           irq
);
  localparam int HIW = AW - 32;

  logic [1:0]     s_code, d_code, ien, flg, set_f, clr_f;
  logic [FSW-1:0] fsel;
  logic           cfg_we, launch_wr, launch_ok, bad_len;
  logic [SZW-1:0] align_mask;
  logic [31:0]    rd_mux;

  assign wcode      = (s_code > d_code) ? s_code : d_code;
  assign align_mask = ~({SZW{1'b1}} << wcode);
  assign bad_len    = (unit_bytes == '0) || ((unit_bytes & align_mask) != '0);
  assign cfg_we     = wen && !busy;
  assign launch_wr  = wen && (addr == RAW'(OFS_LAUNCH));
  assign launch_ok  = launch_wr && wdata[0] && !busy;
  assign go         = launch_ok && !bad_len && (unit_cnt != '0);
  assign abort      = launch_wr && !wdata[0] && busy;

  always_comb begin
    set_f          = '0;
    set_f[FLG_END] = done_p || (launch_ok && !bad_len && (unit_cnt == '0));
    set_f[FLG_ERR] = err_p || (launch_ok && bad_len);
    clr_f          = (wen && (addr == RAW'(OFS_FLAGS))) ? wdata[1:0] : 2'b00;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      RAW'(OFS_FACTOR): begin rd_mux[FSW-1:0] = fsel; rd_mux[16 +: GPW] = gap; end
      RAW'(OFS_SMODE):  begin rd_mux[4] = src_fix; rd_mux[25:24] = s_code; end
      RAW'(OFS_DMODE):  begin rd_mux[4] = dst_fix; rd_mux[25:24] = d_code; end
      RAW'(OFS_SHI):    rd_mux[HIW-1:0] = src_base[AW-1:32];
      RAW'(OFS_DHI):    rd_mux[HIW-1:0] = dst_base[AW-1:32];
      RAW'(OFS_SLO):    rd_mux = src_base[31:0];
      RAW'(OFS_DLO):    rd_mux = dst_base[31:0];
      RAW'(OFS_BYTES):  rd_mux[SZW-1:0] = unit_bytes;
      RAW'(OFS_COUNT):  rd_mux[CNW-1:0] = unit_cnt;
      RAW'(OFS_LAUNCH): rd_mux[0] = busy;
      RAW'(OFS_IEN):    rd_mux[1:0] = ien;
      RAW'(OFS_ACTIVE): rd_mux[0] = busy;
      RAW'(OFS_FLAGS):  rd_mux[1:0] = flg;
      RAW'(OFS_DETECT): rd_mux[1:0] = flg & ien;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base   <= '0;
      dst_base   <= '0;
      src_fix    <= 1'b0;
      dst_fix    <= 1'b0;
      s_code     <= '0;
      d_code     <= '0;
      unit_bytes <= '0;
      unit_cnt   <= '0;
      gap        <= '0;
      fsel       <= '0;
      ien        <= '0;
      flg        <= '0;
      irq        <= 1'b0;
      rdata      <= '0;
    end else begin
      if (cfg_we) begin
        case (addr)
          RAW'(OFS_FACTOR): begin fsel <= wdata[FSW-1:0]; gap <= wdata[16 +: GPW]; end
          RAW'(OFS_SMODE):  begin src_fix <= wdata[4]; s_code <= wdata[25:24]; end
          RAW'(OFS_DMODE):  begin dst_fix <= wdata[4]; d_code <= wdata[25:24]; end
          RAW'(OFS_SHI):    src_base[AW-1:32] <= wdata[HIW-1:0];
          RAW'(OFS_DHI):    dst_base[AW-1:32] <= wdata[HIW-1:0];
          RAW'(OFS_SLO):    src_base[31:0] <= wdata;
          RAW'(OFS_DLO):    dst_base[31:0] <= wdata;
          RAW'(OFS_BYTES):  unit_bytes <= wdata[SZW-1:0];
          RAW'(OFS_COUNT):  unit_cnt <= wdata[CNW-1:0];
          default: ;
        endcase
      end
      if (wen && (addr == RAW'(OFS_IEN))) ien <= wdata[1:0];
      flg <= (flg & ~clr_f) | set_f;
      irq <= |(flg & ien);
      if (ren) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top #(
  parameter int AW  = 64,
  parameter int DW  = 64,
  parameter int SZW = 26,
  parameter int CNW = 16,
  parameter int GPW = 8,
  parameter int FSW = 6,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wen,
  input  logic           reg_ren,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [DW-1:0]  mem_rdata,
  output logic           irq
);
  logic           eng_busy, eng_done, eng_err, go, abort;
  logic [AW-1:0]  src_base, dst_base;
  logic           src_fix, dst_fix;
  logic [1:0]     wcode;
  logic [SZW-1:0] unit_bytes;
  logic [CNW-1:0] unit_cnt;
  logic [GPW-1:0] cfg_gap;

  dma_regs #(.AW(AW), .SZW(SZW), .CNW(CNW), .GPW(GPW), .FSW(FSW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .wen(reg_wen), .ren(reg_ren), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy), .done_p(eng_done),
    .err_p(eng_err), .go(go), .abort(abort), .src_base(src_base),
    .dst_base(dst_base), .src_fix(src_fix), .dst_fix(dst_fix), .wcode(wcode),
    .unit_bytes(unit_bytes), .unit_cnt(unit_cnt), .gap(cfg_gap), .irq(irq)
  );

  dma_engine #(.AW(AW), .DW(DW), .SZW(SZW), .CNW(CNW), .GPW(GPW)) u_eng (
    .clk(clk), .rst(rst), .go(go), .abort(abort), .src_base(src_base),
    .dst_base(dst_base), .src_fix(src_fix), .dst_fix(dst_fix), .wcode(wcode),
    .unit_bytes(unit_bytes), .unit_cnt(unit_cnt), .gap(cfg_gap),
    .busy(eng_busy), .done_p(eng_done), .err_p(eng_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW  = 64,
  parameter int GPW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic           mem_err,
  input logic [AW-1:0]  mem_addr,
  input logic           busy,
  input logic [GPW-1:0] gap,
  input logic           done_p,
  input logic           err_p
);
  logic [15:0] idle_cnt;
  logic        prev_req, prev_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt  <= '0;
      prev_req  <= 1'b0;
      prev_busy <= 1'b0;
    end else begin
      idle_cnt  <= mem_req ? 16'd0 : idle_cnt + 16'd1;
      prev_req  <= mem_req;
      prev_busy <= busy;
    end
  end

  // R3: request held with steady address and direction until acknowledged
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: no request from an idle channel
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R7: an error response ends activity on the next cycle
  a_r7_err_halts: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_err) |=> (!busy && !mem_req));

  // R6: completion ends activity on the next cycle
  a_r6_done_idles: assert property (@(posedge clk) disable iff (rst)
    done_p |=> !busy);

  // R6/R7: end and error never reported together
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(done_p && err_p));

  // R5: idle spacing inside a transfer equals the programmed gap
  a_r5_gap_exact: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !prev_req && prev_busy) |-> (idle_cnt == 16'(gap)));
endmodule

bind dma_chan_top dma_chan_chk #(.AW(AW), .GPW(GPW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
  .busy(eng_busy), .gap(cfg_gap), .done_p(eng_done), .err_p(eng_err)
);

// File: tb/tb_dma_chan_top.sv
module tb_dma_chan_top;
  localparam logic [7:0] O_FAC = 8'h08, O_SMD = 8'h10, O_DMD = 8'h14, O_SHI = 8'h18,
                         O_DHI = 8'h1C, O_SLO = 8'h20, O_DLO = 8'h24, O_SZ  = 8'h28,
                         O_CNT = 8'h2C, O_GO  = 8'h30, O_IEN = 8'h34, O_ST  = 8'h40,
                         O_FLG = 8'h44, O_DET = 8'h48;

  logic        clk, rst, reg_wen, reg_ren, mem_req, mem_we, mem_ack, mem_err, irq;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  dma_chan_top dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { bit we; logic [63:0] addr; logic [1:0] sz; logic [63:0] data; } acc_t;
  acc_t expq[$];
  acc_t e;
  int checks = 0, fails = 0;
  int lat = 0, err_at = -1, acc_cnt = 0, idle = 0, wait_c = 0, gap_exp = 0;
  bit prev_req = 0, first = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [63:0] a, input logic [1:0] code);
    logic [63:0] d = '0;
    for (int b = 0; b < (1 << code); b++) d[8*b +: 8] = 8'(a + 64'(b)) ^ 8'hA5 ^ a[15:8];
    return d;
  endfunction

  // behavioural memory and per-clock comparison against the expected access list
  always @(negedge clk) begin
    mem_ack   = 1'b0;
    mem_err   = 1'b0;
    mem_rdata = '0;
    if (!rst && mem_req) begin
      if (!prev_req && !first) chk(idle == gap_exp, "R5 idle gap", 64'(idle), 64'(gap_exp));
      if (wait_c >= lat) begin
        mem_ack = 1'b1;
        wait_c  = 0;
        if (!mem_we) mem_rdata = pat(mem_addr, mem_size);
        mem_err = (acc_cnt == err_at);
        if (expq.size() > 0) begin
          e = expq.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && mem_size == e.sz,
              "R3/R4 access", {mem_we, mem_size, mem_addr[60:0]}, {e.we, e.sz, e.addr[60:0]});
          if (e.we) chk(mem_wdata == e.data, "R3 write data", mem_wdata, e.data);
        end else begin
          chk(1'b0, "R11/R12 unexpected access", mem_addr, '0);
        end
        if (mem_err) expq.delete();
        acc_cnt++;
        first = 0;
        idle  = 0;
      end else begin
        wait_c++;
      end
    end else if (!rst) begin
      idle++;
    end
    prev_req = mem_req;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_ren = 1'b1; reg_addr = a;
    @(negedge clk); reg_ren = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, tag, 64'(d), 64'(exp));
  endtask

  task automatic prog(input logic [63:0] s, input logic [63:0] d, input bit sf, input logic [1:0] sc,
                      input bit df, input logic [1:0] dc, input int sz, input int cnt, input int g);
    wr(O_SLO, s[31:0]); wr(O_SHI, s[63:32]);
    wr(O_DLO, d[31:0]); wr(O_DHI, d[63:32]);
    wr(O_SMD, (32'(sf) << 4) | (32'(sc) << 24));
    wr(O_DMD, (32'(df) << 4) | (32'(dc) << 24));
    wr(O_SZ, 32'(sz)); wr(O_CNT, 32'(cnt));
    wr(O_FAC, 32'(g) << 16);
    gap_exp = g;
  endtask

  task automatic build(input logic [63:0] s, input logic [63:0] d, input bit sf, input logic [1:0] sc,
                       input bit df, input logic [1:0] dc, input int sz, input int cnt);
    logic [1:0] c = (sc > dc) ? sc : dc;
    int beats = (sz * cnt) >> c;
    for (int i = 0; i < beats; i++) begin
      expq.push_back('{we: 1'b0, addr: s, sz: c, data: '0});
      expq.push_back('{we: 1'b1, addr: d, sz: c, data: pat(s, c)});
      if (!sf) s = s + (64'd1 << c);
      if (!df) d = d + (64'd1 << c);
    end
  endtask

  task automatic launch();
    first = 1; acc_cnt = 0;
    wr(O_GO, 32'd1);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 4000; k++) begin
      rd(O_ST, d);
      if (d[0] == 1'b0) return;
    end
    chk(1'b0, "R6 activity never cleared", 1, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] sa, da;
    int n;
    rst = 1'b1; reg_wen = 0; reg_ren = 0; reg_addr = 0; reg_wdata = 0;
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(irq == 1'b0, "R1 irq", 64'(irq), 0);
    chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 0);
    foreach (dut_offs[i]) rd_chk(dut_offs[i], 32'd0, "R1 reset register");

    // R2: readback with field masking
    wr(O_SZ, 32'hFFFF_FFFF);  rd_chk(O_SZ, 32'h03FF_FFFF, "R2 unit bytes");
    wr(O_CNT, 32'hFFFF_FFFF); rd_chk(O_CNT, 32'h0000_FFFF, "R2 unit count");
    wr(O_SMD, 32'hFFFF_FFFF); rd_chk(O_SMD, 32'h0300_0010, "R2 source mode");
    wr(O_FAC, 32'hFFFF_FFFF); rd_chk(O_FAC, 32'h00FF_003F, "R2 factor");
    wr(O_IEN, 32'hFFFF_FFFF); rd_chk(O_IEN, 32'h0000_0003, "R2 enable");
    wr(O_DHI, 32'h1234_5678); rd_chk(O_DHI, 32'h1234_5678, "R2 dest high");
    wr(O_IEN, 32'd0);

    // R3 R4 R6: stepping both sides, 8-byte beats, no gap
    sa = 64'h0000_0001_0000_1000; da = 64'h0000_0002_0000_8000;
    lat = 0;
    prog(sa, da, 0, 2'd3, 0, 2'd3, 16, 2, 0);
    build(sa, da, 0, 2'd3, 0, 2'd3, 16, 2);
    launch(); wait_idle();
    chk(expq.size() == 0, "R3 beats left", 64'(expq.size()), 0);
    chk(acc_cnt == 8, "R3 access count", 64'(acc_cnt), 8);
    rd_chk(O_FLG, 32'd1, "R6 end flag");
    wr(O_FLG, 32'd3);

    // R4 R5: fixed source, width max of codes 1 and 2, gap 3, slow memory
    sa = 64'h0000_0000_4000_0010; da = 64'h0000_0003_0000_0200;
    lat = 2;
    prog(sa, da, 1, 2'd1, 0, 2'd2, 8, 3, 3);
    build(sa, da, 1, 2'd1, 0, 2'd2, 8, 3);
    launch(); wait_idle();
    chk(acc_cnt == 12 && expq.size() == 0, "R4 fixed side count", 64'(acc_cnt), 12);
    rd_chk(O_FLG, 32'd1, "R6 end flag slow");

    // R10 R9: detect, interrupt, clearing
    chk(irq == 1'b0, "R10 irq masked", 64'(irq), 0);
    rd_chk(O_DET, 32'd0, "R10 detect masked");
    wr(O_IEN, 32'd1);
    rd_chk(O_DET, 32'd1, "R10 detect enabled");
    chk(irq == 1'b1, "R10 irq enabled", 64'(irq), 1);
    wr(O_FLG, 32'd2);
    rd_chk(O_FLG, 32'd1, "R9 other bit write keeps flag");
    wr(O_FLG, 32'd1);
    rd_chk(O_FLG, 32'd0, "R9 flag cleared");
    chk(irq == 1'b0, "R10 irq after clear", 64'(irq), 0);

    // R7: bus error on third access
    wr(O_IEN, 32'd2);
    lat = 1; err_at = 2;
    sa = 64'h0000_0000_0000_2000; da = 64'h0000_0000_0001_0000;
    prog(sa, da, 0, 2'd3, 0, 2'd3, 32, 1, 1);
    build(sa, da, 0, 2'd3, 0, 2'd3, 32, 1);
    launch(); wait_idle();
    rd_chk(O_FLG, 32'd2, "R7 error flag only");
    chk(irq == 1'b1, "R7 irq on error", 64'(irq), 1);
    repeat (30) @(negedge clk);
    chk(acc_cnt == 3, "R7 no access after error", 64'(acc_cnt), 3);
    err_at = -1;
    wr(O_FLG, 32'd3); wr(O_IEN, 32'd0);

    // R8: refused launches
    prog(sa, da, 0, 2'd2, 0, 2'd2, 6, 1, 0);
    launch();
    rd_chk(O_FLG, 32'd2, "R8 misaligned length");
    chk(acc_cnt == 0, "R8 no access misaligned", 64'(acc_cnt), 0);
    wr(O_FLG, 32'd3);
    wr(O_SZ, 32'd0); launch();
    rd_chk(O_FLG, 32'd2, "R8 zero length");
    wr(O_FLG, 32'd3);
    wr(O_SZ, 32'd8); wr(O_CNT, 32'd0); launch();
    rd_chk(O_FLG, 32'd1, "R8 zero count ends");
    rd_chk(O_ST, 32'd0, "R8 not active");
    chk(acc_cnt == 0, "R8 no access zero count", 64'(acc_cnt), 0);
    wr(O_FLG, 32'd3);

    // R11: abort during long gap
    lat = 0;
    prog(sa, da, 0, 2'd3, 0, 2'd3, 8, 8, 20);
    build(sa, da, 0, 2'd3, 0, 2'd3, 8, 8);
    launch();
    while (acc_cnt < 3) @(negedge clk);
    wr(O_GO, 32'd0);
    wait_idle();
    n = acc_cnt;
    expq.delete();
    repeat (60) @(negedge clk);
    chk(acc_cnt == n && n < 16, "R11 quiet after abort", 64'(acc_cnt), 64'(n));
    rd_chk(O_FLG, 32'd0, "R11 no flag on abort");

    // R12: setup and relaunch ignored while active
    prog(sa, da, 0, 2'd3, 0, 2'd3, 16, 1, 20);
    build(sa, da, 0, 2'd3, 0, 2'd3, 16, 1);
    launch();
    while (acc_cnt < 1) @(negedge clk);
    wr(O_SLO, 32'hDEAD_0000);
    wr(O_SZ, 32'd8);
    wr(O_GO, 32'd1);
    wait_idle();
    chk(acc_cnt == 4 && expq.size() == 0, "R12 transfer unchanged", 64'(acc_cnt), 4);
    rd_chk(O_SLO, sa[31:0], "R12 source kept");
    rd_chk(O_SZ, 32'd16, "R12 length kept");
    rd_chk(O_FLG, 32'd1, "R12 end flag");

    report();
  end

  localparam logic [7:0] dut_offs [14] = '{8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                                           8'h28, 8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48};
endmodule